// File: doc/BRIEF.md
# PCI Power Management Control Register

This block holds the power-management control and status word of a host controller function. The word sits in configuration space at byte offset 54h. The word carries three things: a sticky PME status flag, a PME enable, and a two-bit power state. The block raises an internal PME request when the status flag and the enable are both set. It tells the memory-space decoder whether accesses may be accepted, and it refuses them while the function is in D3hot. When software takes the function from D3hot back to D0, the block issues a one-clock warm reset to the rest of the function.

The PME flag and the PME enable belong to the suspend power well. Only the suspend-well reset clears them, so they survive both the core-well reset and the warm reset. The power state belongs to the core well and returns to D0 on a core reset. Each reset input is asserted asynchronously. Each is released through its own two-stage synchronizer, so a domain starts working on the third rising clock edge after its reset pin goes high.

Configuration reads are combinational. Writes take effect on the clock edge that samples them. Byte enables select the lanes: lane 0 covers bits 7:0 and lane 1 covers bits 15:8.

Top module: `pm_ctrl_reg`

## Requirements
- R1: A read at word address 2Ah (byte 54h) returns {PME status at bit 15, zeros at 14:9, PME enable at bit 8, zeros at 7:2, power state at 1:0}. A read at any other word address returns 0000h. After both resets the word reads 0000h.
- R2: A high pme_event sampled on a clock edge sets PME status whatever the enable holds. If a clear request is sampled on the same edge, the event wins.
- R3: A write with lane 1 enabled and bit 15 set clears PME status. A write with bit 15 at 0 leaves PME status unchanged.
- R4: A write with lane 1 enabled loads PME enable from bit 8. Writes to bits 14:9 and 7:2 are ignored, and those bits always read 0.
- R5: pme_req is 1 exactly when PME status and PME enable are both 1.
- R6: A write with lane 0 enabled and bits 1:0 equal to 00b (D0) or 11b (D3hot) loads the power state. Values 01b and 10b are discarded and leave the state unchanged.
- R7: mem_access_ok is 0 exactly while the power state is D3hot. Configuration reads and writes work in every state.
- R8: warm_rst is high for exactly one clock, in the cycle after the edge that samples a write moving the state from D3hot to D0. A D0-to-D0 write produces no pulse.
- R9: A power-state write sampled on the edge at the end of the warm_rst cycle is discarded, and the state stays D0.
- R10: core_rst_n returns the power state to D0 and drops warm_rst, and leaves PME status and PME enable unchanged. susp_rst_n clears PME status and PME enable, and leaves the power state unchanged.
- R11: A write with only lane 1 enabled cannot change the power state. A write with only lane 0 enabled cannot change PME status or PME enable.
- R12: Each reset acts at once when its pin goes low. After the pin goes high, the domain ignores writes and events on the first two rising edges and acts from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| core_rst_n | input | 1 | Core-well reset, active low |
| susp_rst_n | input | 1 | Suspend-well reset, active low |
| cfg_wr | input | 1 | Configuration write strobe, one write per sampled cycle |
| cfg_addr | input | 7 | Configuration word address (byte offset divided by two) |
| cfg_be | input | 2 | Byte-lane enables for writes |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data, combinational on cfg_addr |
| pme_event | input | 1 | Wake condition from the function, sampled each clock |
| pme_req | output | 1 | Internal PME request |
| mem_access_ok | output | 1 | High when memory-space accesses may be accepted |
| warm_rst | output | 1 | One-clock warm reset of the function |

## Verification
The hardest case to reach is the edge at the end of the warm reset pulse. The stimulus has to place a power-state write exactly one cycle after a D3hot-to-D0 write, so the bench issues back-to-back writes without an idle cycle between them. A second hard case is a core reset while a PME is pending and enabled, which has to leave the suspend-well bits intact. A third is a set and a clear landing on the same edge. The bench reaches each of these with directed write sequences, and a behavioural model compares every output on every cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int DATA_W   = 16;
  localparam int LANE_W   = 8;
  localparam int LANES    = DATA_W / LANE_W;
  localparam int STS_BIT  = 15;
  localparam int EN_BIT   = 8;
  localparam int PS_W     = 2;

  localparam logic [PS_W-1:0] PS_D0    = 2'b00;
  localparam logic [PS_W-1:0] PS_D3HOT = 2'b11;

  function automatic logic ps_legal(input logic [PS_W-1:0] v);
    return (v == PS_D0) || (v == PS_D3HOT);
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode #(
  parameter int                WADDR_W  = 7,
  parameter int                LANES    = 2,
  parameter logic [WADDR_W-1:0] REG_WADDR = 7'h2A
) (
  input  logic               cfg_wr,
  input  logic [WADDR_W-1:0] cfg_addr,
  input  logic [LANES-1:0]   cfg_be,
  output logic               reg_hit,
  output logic [LANES-1:0]   lane_wr
);
  assign reg_hit = (cfg_addr == REG_WADDR);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = cfg_wr & reg_hit & cfg_be[g];
  end
endmodule

// File: rtl/pm_pme_bits.sv
module pm_pme_bits
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pme_event,
  input  logic              wr_hi,
  input  logic [LANE_W-1:0] wdata_hi,
  output logic              pme_sts,
  output logic              pme_en
);
  localparam int STS_POS = STS_BIT - LANE_W;
  localparam int EN_POS  = EN_BIT - LANE_W;

  logic sts_d, sts_ce;
  logic en_d, en_ce;

  always_comb begin
    sts_ce = pme_event | wr_hi;
    sts_d  = pme_sts;
    if (wr_hi && wdata_hi[STS_POS]) begin
      sts_d = 1'b0;
    end
    if (pme_event) begin
      sts_d = 1'b1;
    end
    en_ce = wr_hi;
    en_d  = wdata_hi[EN_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_sts <= 1'b0;
    end else if (sts_ce) begin
      pme_sts <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pme_en <= 1'b0;
    end else if (en_ce) begin
      pme_en <= en_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wdata_hi[LANE_W-1:STS_POS+1], wdata_hi[STS_POS-1:EN_POS+1],
                         wdata_hi[EN_POS-1:0]};
endmodule

// File: rtl/pm_pstate.sv
module pm_pstate
  import pm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic [PS_W-1:0] wdata_ps,
  output logic [PS_W-1:0] pstate,
  output logic            warm_rst
);
  logic [PS_W-1:0] ps_d;
  logic            ps_ce;
  logic            warm_d;
  logic            take;

  always_comb begin
    take   = wr_lo && ps_legal(wdata_ps) && !warm_rst;
    ps_ce  = warm_rst | take;
    ps_d   = warm_rst ? PS_D0 : wdata_ps;
    warm_d = take && (pstate == PS_D3HOT) && (wdata_ps == PS_D0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= PS_D0;
    end else if (ps_ce) begin
      pstate <= ps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_rst <= 1'b0;
    end else begin
      warm_rst <= warm_d;
    end
  end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_pkg::*;
#(
  parameter int                 WADDR_W    = 7,
  parameter logic [WADDR_W-1:0] REG_WADDR  = 7'h2A,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               core_rst_n,
  input  logic               susp_rst_n,
  input  logic               cfg_wr,
  input  logic [WADDR_W-1:0] cfg_addr,
  input  logic [LANES-1:0]   cfg_be,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               pme_event,
  output logic               pme_req,
  output logic               mem_access_ok,
  output logic               warm_rst
);
  logic              core_rst_int_n;
  logic              susp_rst_int_n;
  logic              reg_hit;
  logic [LANES-1:0]  lane_wr;
  logic              pme_sts;
  logic              pme_en;
  logic [PS_W-1:0]   pstate;
  logic [DATA_W-1:0] rd_word;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk      (clk),
    .rst_in_n (core_rst_n),
    .rst_out_n(core_rst_int_n)
  );

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_susp_sync (
    .clk      (clk),
    .rst_in_n (susp_rst_n),
    .rst_out_n(susp_rst_int_n)
  );

  pm_cfg_decode #(.WADDR_W(WADDR_W), .LANES(LANES), .REG_WADDR(REG_WADDR)) u_dec (
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .cfg_be  (cfg_be),
    .reg_hit (reg_hit),
    .lane_wr (lane_wr)
  );

  pm_pme_bits u_pme (
    .clk      (clk),
    .rst_n    (susp_rst_int_n),
    .pme_event(pme_event),
    .wr_hi    (lane_wr[1]),
    .wdata_hi (cfg_wdata[DATA_W-1:LANE_W]),
    .pme_sts  (pme_sts),
    .pme_en   (pme_en)
  );

  pm_pstate u_ps (
    .clk     (clk),
    .rst_n   (core_rst_int_n),
    .wr_lo   (lane_wr[0]),
    .wdata_ps(cfg_wdata[PS_W-1:0]),
    .pstate  (pstate),
    .warm_rst(warm_rst)
  );

  always_comb begin
    rd_word          = '0;
    rd_word[STS_BIT] = pme_sts;
    rd_word[EN_BIT]  = pme_en;
    rd_word[PS_W-1:0] = pstate;
    cfg_rdata        = reg_hit ? rd_word : '0;
  end

  assign pme_req       = pme_sts & pme_en;
  assign mem_access_ok = (pstate != PS_D3HOT);

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[LANE_W-1:PS_W];
endmodule

// File: rtl/pm_ctrl_reg_chk.sv
module pm_ctrl_reg_chk (
  input logic        clk,
  input logic        core_rst_int_n,
  input logic        susp_rst_int_n,
  input logic        pme_event,
  input logic [1:0]  lane_wr,
  input logic [15:0] cfg_wdata,
  input logic        pme_sts,
  input logic        pme_en,
  input logic [1:0]  pstate,
  input logic        warm_rst,
  input logic        mem_access_ok
);
  AST_EVENT_SETS_STS: assert property (@(posedge clk) disable iff (!susp_rst_int_n)
    pme_event |=> pme_sts); // R2

  AST_PME_HOLD: assert property (@(posedge clk) disable iff (!susp_rst_int_n)
    (!pme_event && !lane_wr[1]) |=> ($stable(pme_sts) && $stable(pme_en))); // R11

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!core_rst_int_n)
    (pstate == 2'b00) || (pstate == 2'b11)); // R6

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!core_rst_int_n)
    (!lane_wr[0] && !warm_rst) |=> $stable(pstate)); // R11

  AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!core_rst_int_n)
    warm_rst |=> !warm_rst); // R8

  AST_WARM_CAUSE: assert property (@(posedge clk) disable iff (!core_rst_int_n)
    $rose(warm_rst) |-> ($past(pstate) == 2'b11 && pstate == 2'b00)); // R8

  AST_MEM_BLOCK_CAUSE: assert property (@(posedge clk) disable iff (!core_rst_int_n)
    $fell(mem_access_ok) |-> $past(lane_wr[0] && cfg_wdata[1:0] == 2'b11)); // R7
endmodule

bind pm_ctrl_reg pm_ctrl_reg_chk u_chk (
  .clk           (clk),
  .core_rst_int_n(core_rst_int_n),
  .susp_rst_int_n(susp_rst_int_n),
  .pme_event     (pme_event),
  .lane_wr       (lane_wr),
  .cfg_wdata     (cfg_wdata),
  .pme_sts       (pme_sts),
  .pme_en        (pme_en),
  .pstate        (pstate),
  .warm_rst      (warm_rst),
  .mem_access_ok (mem_access_ok)
);

// File: tb/pm_ctrl_reg_tb.sv
`timescale 1ns/100ps
module pm_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        core_rst_n;
  logic        susp_rst_n;
  logic        cfg_wr;
  logic [6:0]  cfg_addr;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        pme_event;
  logic        pme_req;
  logic        mem_access_ok;
  logic        warm_rst;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pm_ctrl_reg u_dut (
    .clk(clk), .core_rst_n(core_rst_n), .susp_rst_n(susp_rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pme_event(pme_event), .pme_req(pme_req),
    .mem_access_ok(mem_access_ok), .warm_rst(warm_rst)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int       m_ccnt = 0;
  int       m_scnt = 0;
  int       m_state = 0;
  bit       m_warm = 0;
  bit       m_sts = 0;
  bit       m_en = 0;

  always @(posedge clk or negedge core_rst_n or negedge susp_rst_n) begin
    bit hit;
    int v;
    bit nwarm;
    if (clk === 1'b1) begin
      hit = (cfg_wr === 1'b1) && (cfg_addr == 7'h2A);
      v = int'(cfg_wdata[1:0]);
      if (m_ccnt >= 2) begin
        nwarm = 0;
        if (m_warm) m_state = 0;
        else if (hit && cfg_be[0] && (v == 0 || v == 3)) begin
          if (m_state == 3 && v == 0) nwarm = 1;
          m_state = v;
        end
        m_warm = nwarm;
      end
      if (m_scnt >= 2) begin
        if (hit && cfg_be[1]) begin
          if (cfg_wdata[15]) m_sts = 0;
          m_en = cfg_wdata[8];
        end
        if (pme_event === 1'b1) m_sts = 1;
      end
      if (core_rst_n === 1'b1 && m_ccnt < 2) m_ccnt++;
      if (susp_rst_n === 1'b1 && m_scnt < 2) m_scnt++;
    end
    if (core_rst_n !== 1'b1) begin m_ccnt = 0; m_state = 0; m_warm = 0; end
    if (susp_rst_n !== 1'b1) begin m_scnt = 0; m_sts = 0; m_en = 0; end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [15:0] exp_rd;
    exp_rd = 16'h0000;
    if (cfg_addr == 7'h2A) exp_rd = {m_sts, 6'b0, m_en, 6'b0, 2'(m_state)};
    check("R1 rdata", cfg_rdata, exp_rd);
    check("R5 pme_req", {15'b0, pme_req}, {15'b0, m_sts & m_en});
    check("R7 mem_access_ok", {15'b0, mem_access_ok}, {15'b0, m_state != 3});
    check("R8 warm_rst", {15'b0, warm_rst}, {15'b0, m_warm});
  end

  task automatic drive(input bit wr, input logic [6:0] a, input logic [1:0] be,
                       input logic [15:0] d, input bit ev);
    @(posedge clk); #1;
    cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = d; pme_event = ev;
  endtask

  task automatic idle();
    drive(0, 7'h2A, 2'b00, 16'h0000, 0);
  endtask

  task automatic wr16(input logic [1:0] be, input logic [15:0] d);
    drive(1, 7'h2A, be, d, 0);
  endtask

  task automatic rd_check(input string req, input logic [15:0] exp);
    idle();
    @(negedge clk);
    check(req, cfg_rdata, exp);
  endtask

  task automatic set_pin(input bit core, input bit susp);
    @(negedge clk); #1;
    core_rst_n = core; susp_rst_n = susp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    core_rst_n = 0; susp_rst_n = 0;
    cfg_wr = 0; cfg_addr = 7'h2A; cfg_be = 0; cfg_wdata = 0; pme_event = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", cfg_rdata, 16'h0000);
    check("R10 no warm in reset", {15'b0, warm_rst}, 16'h0000);
    // R12: write landing on the second edge after release is ignored
    set_pin(1, 1);
    drive(1, 7'h2A, 2'b11, 16'h8103, 1);
    rd_check("R12 write during sync release", 16'h0000);
    repeat (2) idle();
    // R1: other address reads zero
    wr16(2'b11, 16'h0103);
    drive(0, 7'h20, 2'b00, 16'h0000, 0);
    @(negedge clk);
    check("R1 foreign address", cfg_rdata, 16'h0000);
    rd_check("R6 D3hot written", 16'h0103);
    check("R7 memory blocked", {15'b0, mem_access_ok}, 16'h0000);
    // R6: illegal values dropped
    wr16(2'b01, 16'h0001);
    rd_check("R6 value 01 dropped", 16'h0103);
    wr16(2'b01, 16'h0002);
    rd_check("R6 value 10 dropped", 16'h0103);
    // R11: upper lane only cannot change state
    wr16(2'b10, 16'h0100);
    rd_check("R11 upper lane keeps state", 16'h0103);
    // R8: D3hot to D0 gives one pulse
    wr16(2'b01, 16'h0000);
    idle();
    @(negedge clk);
    check("R8 warm pulse high", {15'b0, warm_rst}, 16'h0001);
    check("R7 memory allowed", {15'b0, mem_access_ok}, 16'h0001);
    idle();
    @(negedge clk);
    check("R8 warm pulse ends", {15'b0, warm_rst}, 16'h0000);
    // R8: D0 to D0 no pulse
    wr16(2'b01, 16'h0000);
    idle();
    @(negedge clk);
    check("R8 D0 rewrite no pulse", {15'b0, warm_rst}, 16'h0000);
    // R9: write during warm pulse is dropped
    wr16(2'b01, 16'h0003);
    wr16(2'b01, 16'h0000);
    wr16(2'b01, 16'h0003);
    rd_check("R9 write in pulse cycle dropped", 16'h0100);
    // R2: event sets status with enable clear
    wr16(2'b10, 16'h0000);
    drive(0, 7'h2A, 2'b00, 16'h0000, 1);
    rd_check("R2 event sets status", 16'h8000);
    check("R5 no request without enable", {15'b0, pme_req}, 16'h0000);
    // R11: lower lane only cannot clear status
    wr16(2'b01, 16'hFF00);
    rd_check("R11 lower lane keeps PME bits", 16'h8000);
    // R3: writing 0 to status leaves it; R4 enable set
    wr16(2'b10, 16'h0100);
    rd_check("R3 zero write keeps status", 16'h8100);
    check("R5 request asserted", {15'b0, pme_req}, 16'h0001);
    // R2: set and clear on same edge
    drive(1, 7'h2A, 2'b10, 16'h8100, 1);
    rd_check("R2 event beats clear", 16'h8100);
    // R3 and R4: clear status, reserved bits ignored
    wr16(2'b11, 16'hFFFC);
    rd_check("R4 reserved bits read zero", 16'h0100);
    // R10: core reset keeps suspend bits
    drive(0, 7'h2A, 2'b00, 16'h0000, 1);
    wr16(2'b01, 16'h0003);
    set_pin(0, 1);
    repeat (2) idle();
    set_pin(1, 1);
    repeat (3) idle();
    rd_check("R10 core reset keeps PME bits", 16'h8100);
    // R10: suspend reset keeps state
    wr16(2'b01, 16'h0003);
    set_pin(1, 0);
    repeat (2) idle();
    set_pin(1, 1);
    repeat (3) idle();
    rd_check("R10 suspend reset keeps state", 16'h0003);
    repeat (4) idle();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule